// File: doc/BRIEF.md
# Branch and Skip Sequencer

This unit works out the next program counter once an instruction has been recognised as belonging to the branch or skip groups. Decode supplies the operation class, a condition code and a polarity bit. It also supplies the program counter as it stands after the opcode byte, which is the address of the first operand byte. From these the unit samples the status inputs when it accepts the operation. The status inputs are the Q output flag, the DF carry flag, the accumulator value (tested for zero), four external flag lines and the interrupt enable flag.

Short branches are absolute within a 256-byte page. A short branch replaces only the low byte of the program counter. The page comes from the address that follows the operand byte. Long branches load a full 16-bit target from two operand bytes, high byte first. Short branches that are not taken, and long skips whose condition holds, simply step the program counter over the bytes that follow. The unit tells the fetch logic how many operand bytes it still needs, one at a time, through a request/valid exchange. It emits the new program counter as a one-cycle pulse.

Top module: `branch_skip_unit`

## Requirements
- R1: A taken short branch fetches one byte at `op_pc` and produces {(`op_pc`+1)[15:8], operand byte}, so an operand at xxFF lands in the following page.
- R2: Short condition codes (op_kind 2'b00) are: 0 always, 1 Q, 2 accumulator equal to zero, 3 DF, 4 to 7 external flags 0 to 3. The branch is taken when the condition value XOR `op_invert` is 1.
- R3: A short branch that is not taken fetches nothing and produces `op_pc`+1, which is a one-byte skip.
- R4: A taken long branch (op_kind 2'b01) fetches a byte at `op_pc` and then a byte at `op_pc`+1. It produces {first byte, second byte}.
- R5: Long branches use only op_cond[1:0], with the same meaning as codes 0 to 3 of R2, and ignore op_cond[2]. If not taken, they fetch nothing and produce `op_pc`+2.
- R6: A long skip (op_kind 2'b10) never fetches. When op_cond[2]=1 its condition is `int_en`; otherwise it uses op_cond[1:0] as in R5. It produces `op_pc`+2 when the condition XOR `op_invert` is 1, and `op_pc` when it is not.
- R7: All program counter and operand address arithmetic wraps modulo 2^16.
- R8: `pc_valid` is a one-cycle pulse. It comes one cycle after acceptance when no byte is fetched, and one cycle after the last operand byte is accepted.
- R9: While `busy` is 1, `op_valid` is ignored. op_kind 2'b11 is never accepted.
- R10: After reset, `busy`, `byte_req` and `pc_valid` are 0, and `imm_need` is 0.
- R11: `imm_need` shows how many operand bytes are still to be fetched (2, 1 or 0). It is 0 whenever the unit is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Branch/skip operation offered |
| op_kind | input | 2 | 00 short branch, 01 long branch, 10 long skip, 11 reserved |
| op_cond | input | 3 | Condition code |
| op_invert | input | 1 | Polarity: 1 inverts the condition |
| op_pc | input | 16 | Program counter after the opcode byte |
| flag_q | input | 1 | Q output flag |
| flag_df | input | 1 | DF carry flag |
| acc | input | 8 | Accumulator, tested for zero |
| ext_flag | input | 4 | External flag lines |
| int_en | input | 1 | Interrupt enable flag |
| byte_req | output | 1 | An operand byte is requested |
| byte_addr | output | 16 | Address of the requested byte |
| byte_valid | input | 1 | Operand byte present on byte_in |
| byte_in | input | 8 | Operand byte |
| imm_need | output | 2 | Operand bytes still needed |
| busy | output | 1 | Operation in progress |
| pc_valid | output | 1 | New program counter pulse |
| pc_out | output | 16 | New program counter |

## Verification
The hardest situations to reach from the ports are the address wraps. One is a short-branch operand at the last byte of a page, where the target page must come from the following address. The other is a long branch whose two operand bytes straddle address FFFF/0000. The vector table places `op_pc` at xxFF and at FFFF, and the bench compares every requested `byte_addr` against a wrapped count of its own. The ignore rule is reached by offering a second operation while the unit waits for a long-branch operand. The bench then checks that exactly one result pulse appears and that it carries the first operation's target.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    typedef enum logic [1:0] {
        K_SHORT = 2'b00,
        K_LONG  = 2'b01,
        K_LSKIP = 2'b10,
        K_RSVD  = 2'b11
    } kind_e;

    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_FETCH = 1'b1
    } state_e;

endpackage

// File: rtl/bsq_cond_eval.sv
module bsq_cond_eval
    import bsq_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int EXT_N  = 4,
    parameter int COND_W = 3
) (
    input  kind_e              kind,
    input  logic [COND_W-1:0]  cond,
    input  logic               invert,
    input  logic               flag_q,
    input  logic               flag_df,
    input  logic [BYTE_W-1:0]  acc,
    input  logic [EXT_N-1:0]   ext_flag,
    input  logic               int_en,
    output logic               taken
);
    localparam int N_TESTS = 1 << COND_W;
    localparam int LONG_W  = COND_W - 1;

    logic [N_TESTS-1:0] tests;
    logic               acc_zero;
    logic               raw;
    logic [COND_W-1:0]  long_idx;

    assign acc_zero = (acc == '0);
    assign long_idx = {1'b0, cond[LONG_W-1:0]};

    // test slot per condition code; slots past the external flags read 0
    generate
        for (genvar i = 0; i < N_TESTS; i++) begin : g_test
            if (i == 0) begin : g_always
                assign tests[i] = 1'b1;
            end else if (i == 1) begin : g_q
                assign tests[i] = flag_q;
            end else if (i == 2) begin : g_zero
                assign tests[i] = acc_zero;
            end else if (i == 3) begin : g_df
                assign tests[i] = flag_df;
            end else if (i - 4 < EXT_N) begin : g_ext
                assign tests[i] = ext_flag[i-4];
            end else begin : g_none
                assign tests[i] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        case (kind)
            K_SHORT: raw = tests[cond];
            K_LONG:  raw = tests[long_idx];
            K_LSKIP: raw = cond[COND_W-1] ? int_en : tests[long_idx];
            default: raw = 1'b0;
        endcase
        taken = raw ^ invert;
    end

endmodule

// File: rtl/bsq_step_adder.sv
module bsq_step_adder #(
    parameter int ADDR_W   = 16,
    parameter int MAX_STEP = 2
) (
    input  logic [ADDR_W-1:0]               base,
    output logic [MAX_STEP:0][ADDR_W-1:0]   sums
);
    generate
        for (genvar k = 0; k <= MAX_STEP; k++) begin : g_step
            assign sums[k] = base + ADDR_W'(k);
        end
    endgenerate
endmodule

// File: rtl/branch_skip_unit.sv
module branch_skip_unit
    import bsq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8,
    parameter int EXT_N  = 4,
    parameter int COND_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [1:0]         op_kind,
    input  logic [COND_W-1:0]  op_cond,
    input  logic               op_invert,
    input  logic [ADDR_W-1:0]  op_pc,
    input  logic               flag_q,
    input  logic               flag_df,
    input  logic [BYTE_W-1:0]  acc,
    input  logic [EXT_N-1:0]   ext_flag,
    input  logic               int_en,
    output logic               byte_req,
    output logic [ADDR_W-1:0]  byte_addr,
    input  logic               byte_valid,
    input  logic [BYTE_W-1:0]  byte_in,
    output logic [1:0]         imm_need,
    output logic               busy,
    output logic               pc_valid,
    output logic [ADDR_W-1:0]  pc_out
);
    localparam int HI_W     = ADDR_W - BYTE_W;
    localparam int MAX_STEP = 2;

    typedef struct packed {
        state_e            st;
        logic [1:0]        need;
        logic [ADDR_W-1:0] addr;
        logic [HI_W-1:0]   hi;
        logic              pc_valid;
        logic [ADDR_W-1:0] pc;
    } seq_t;

    seq_t  seq_d, seq_q;
    kind_e kind;
    logic  taken;
    logic [MAX_STEP:0][ADDR_W-1:0] steps;

    assign kind = kind_e'(op_kind);

    bsq_cond_eval #(
        .BYTE_W (BYTE_W),
        .EXT_N  (EXT_N),
        .COND_W (COND_W)
    ) u_cond (
        .kind     (kind),
        .cond     (op_cond),
        .invert   (op_invert),
        .flag_q   (flag_q),
        .flag_df  (flag_df),
        .acc      (acc),
        .ext_flag (ext_flag),
        .int_en   (int_en),
        .taken    (taken)
    );

    bsq_step_adder #(
        .ADDR_W   (ADDR_W),
        .MAX_STEP (MAX_STEP)
    ) u_steps (
        .base (op_pc),
        .sums (steps)
    );

    always_comb begin
        seq_d          = seq_q;
        seq_d.pc_valid = 1'b0;
        case (seq_q.st)
            S_IDLE: begin
                if (op_valid && kind != K_RSVD) begin
                    case (kind)
                        K_SHORT: begin
                            if (taken) begin
                                seq_d.st   = S_FETCH;
                                seq_d.need = 2'd1;
                                seq_d.addr = op_pc;
                                seq_d.hi   = steps[1][ADDR_W-1:BYTE_W];
                            end else begin
                                seq_d.pc_valid = 1'b1;
                                seq_d.pc       = steps[1];
                            end
                        end
                        K_LONG: begin
                            if (taken) begin
                                seq_d.st   = S_FETCH;
                                seq_d.need = 2'd2;
                                seq_d.addr = op_pc;
                            end else begin
                                seq_d.pc_valid = 1'b1;
                                seq_d.pc       = steps[2];
                            end
                        end
                        default: begin
                            seq_d.pc_valid = 1'b1;
                            seq_d.pc       = taken ? steps[2] : steps[0];
                        end
                    endcase
                end
            end
            S_FETCH: begin
                if (byte_valid) begin
                    if (seq_q.need == 2'd1) begin
                        seq_d.st       = S_IDLE;
                        seq_d.need     = 2'd0;
                        seq_d.pc_valid = 1'b1;
                        seq_d.pc       = {seq_q.hi, byte_in};
                    end else begin
                        seq_d.need = 2'd1;
                        seq_d.hi   = HI_W'(byte_in);
                        seq_d.addr = seq_q.addr + ADDR_W'(1);
                    end
                end
            end
            default: seq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: S_IDLE, need: 2'd0, addr: '0, hi: '0,
                       pc_valid: 1'b0, pc: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign byte_req  = (seq_q.st == S_FETCH);
    assign byte_addr = seq_q.addr;
    assign imm_need  = seq_q.need;
    assign busy      = (seq_q.st != S_IDLE);
    assign pc_valid  = seq_q.pc_valid;
    assign pc_out    = seq_q.pc;

endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [1:0]        op_kind,
    input logic              byte_req,
    input logic [ADDR_W-1:0] byte_addr,
    input logic              byte_valid,
    input logic [BYTE_W-1:0] byte_in,
    input logic [1:0]        imm_need,
    input logic              busy,
    input logic              pc_valid,
    input logic [ADDR_W-1:0] pc_out
);
    // R6, R8: a long skip completes without any fetch
    a_r6_skip_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !busy && op_kind == 2'b10 |=> pc_valid && !busy);

    // R4: high byte taken first, then the next address is requested
    a_r4_hi_then_lo: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req && byte_valid && imm_need == 2'd2
        |=> byte_req && imm_need == 2'd1 && byte_addr == $past(byte_addr) + 1'b1);

    // R1: the last operand byte becomes the low byte of the result
    a_r1_low_from_byte: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req && byte_valid && imm_need == 2'd1
        |=> pc_valid && pc_out[BYTE_W-1:0] == $past(byte_in));

    // R8: a result only appears when the unit is idle
    a_r8_valid_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        pc_valid |-> !busy);

    // R11: nothing is outstanding while idle
    a_r11_need_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> imm_need == 2'd0);

    // R9: the reserved class is never accepted
    a_r9_rsvd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !busy && op_kind == 2'b11 |=> !busy && !pc_valid);
endmodule

bind branch_skip_unit bsq_checker #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_kind    (op_kind),
    .byte_req   (byte_req),
    .byte_addr  (byte_addr),
    .byte_valid (byte_valid),
    .byte_in    (byte_in),
    .imm_need   (imm_need),
    .busy       (busy),
    .pc_valid   (pc_valid),
    .pc_out     (pc_out)
);

// File: tb/branch_skip_unit_bench.sv
module branch_skip_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'b00;
    logic [2:0]  op_cond = 3'd0;
    logic        op_invert = 1'b0;
    logic [15:0] op_pc = 16'h0;
    logic        flag_q = 1'b0;
    logic        flag_df = 1'b0;
    logic [7:0]  acc = 8'h0;
    logic [3:0]  ext_flag = 4'h0;
    logic        int_en = 1'b0;
    logic        byte_req;
    logic [15:0] byte_addr;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_in = 8'h0;
    logic [1:0]  imm_need;
    logic        busy;
    logic        pc_valid;
    logic [15:0] pc_out;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    branch_skip_unit u_branch_skip_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_cond(op_cond), .op_invert(op_invert), .op_pc(op_pc),
        .flag_q(flag_q), .flag_df(flag_df), .acc(acc), .ext_flag(ext_flag),
        .int_en(int_en), .byte_req(byte_req), .byte_addr(byte_addr),
        .byte_valid(byte_valid), .byte_in(byte_in), .imm_need(imm_need),
        .busy(busy), .pc_valid(pc_valid), .pc_out(pc_out)
    );

    typedef struct packed {
        logic [1:0]  kind;
        logic [2:0]  cond;
        logic        inv;
        logic [15:0] pc;
        logic        q;
        logic        df;
        logic [7:0]  acc;
        logic [3:0]  ext;
        logic        ie;
        logic [7:0]  b0;
        logic [7:0]  b1;
        logic [15:0] exp_pc;
        logic [1:0]  exp_need;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 3'd0, 1'b0, 16'h1234, 1'b0, 1'b0, 8'h55, 4'h0, 1'b0, 8'h56, 8'h00, 16'h1256, 2'd1}, // 0 R1
        '{2'd0, 3'd0, 1'b1, 16'h1234, 1'b0, 1'b0, 8'h55, 4'h0, 1'b0, 8'h00, 8'h00, 16'h1235, 2'd0}, // 1 R3
        '{2'd0, 3'd1, 1'b0, 16'h2000, 1'b1, 1'b0, 8'h55, 4'h0, 1'b0, 8'h80, 8'h00, 16'h2080, 2'd1}, // 2 R2
        '{2'd0, 3'd1, 1'b0, 16'h2000, 1'b0, 1'b0, 8'h55, 4'h0, 1'b0, 8'h00, 8'h00, 16'h2001, 2'd0}, // 3 R2
        '{2'd0, 3'd2, 1'b0, 16'h3000, 1'b0, 1'b0, 8'h00, 4'h0, 1'b0, 8'h10, 8'h00, 16'h3010, 2'd1}, // 4 R2
        '{2'd0, 3'd2, 1'b1, 16'h3000, 1'b0, 1'b0, 8'h00, 4'h0, 1'b0, 8'h00, 8'h00, 16'h3001, 2'd0}, // 5 R2
        '{2'd0, 3'd3, 1'b1, 16'h3100, 1'b0, 1'b1, 8'h55, 4'h0, 1'b0, 8'h00, 8'h00, 16'h3101, 2'd0}, // 6 R2
        '{2'd0, 3'd6, 1'b0, 16'h3200, 1'b0, 1'b0, 8'h55, 4'h4, 1'b0, 8'hEE, 8'h00, 16'h32EE, 2'd1}, // 7 R2
        '{2'd0, 3'd7, 1'b0, 16'h3200, 1'b0, 1'b0, 8'h55, 4'h4, 1'b0, 8'h00, 8'h00, 16'h3201, 2'd0}, // 8 R2
        '{2'd0, 3'd0, 1'b0, 16'h12FF, 1'b0, 1'b0, 8'h55, 4'h0, 1'b0, 8'h34, 8'h00, 16'h1334, 2'd1}, // 9 R1 page edge
        '{2'd1, 3'd0, 1'b0, 16'h4000, 1'b0, 1'b0, 8'h55, 4'h0, 1'b0, 8'hAB, 8'hCD, 16'hABCD, 2'd2}, // 10 R4
        '{2'd1, 3'd1, 1'b1, 16'h4000, 1'b1, 1'b0, 8'h55, 4'h0, 1'b0, 8'h00, 8'h00, 16'h4002, 2'd0}, // 11 R5
        '{2'd1, 3'd3, 1'b0, 16'h4010, 1'b0, 1'b1, 8'h55, 4'h0, 1'b0, 8'h01, 8'h02, 16'h0102, 2'd2}, // 12 R4
        '{2'd1, 3'd5, 1'b0, 16'h4020, 1'b1, 1'b0, 8'h55, 4'h0, 1'b0, 8'h77, 8'h88, 16'h7788, 2'd2}, // 13 R5 bit2 ignored
        '{2'd2, 3'd4, 1'b0, 16'h5000, 1'b0, 1'b0, 8'h55, 4'h0, 1'b1, 8'h00, 8'h00, 16'h5002, 2'd0}, // 14 R6
        '{2'd2, 3'd4, 1'b1, 16'h5000, 1'b0, 1'b0, 8'h55, 4'h0, 1'b1, 8'h00, 8'h00, 16'h5000, 2'd0}, // 15 R6
        '{2'd2, 3'd2, 1'b0, 16'h5100, 1'b0, 1'b0, 8'h01, 4'h0, 1'b0, 8'h00, 8'h00, 16'h5100, 2'd0}, // 16 R6
        '{2'd2, 3'd2, 1'b1, 16'h5100, 1'b0, 1'b0, 8'h01, 4'h0, 1'b0, 8'h00, 8'h00, 16'h5102, 2'd0}, // 17 R6
        '{2'd2, 3'd0, 1'b0, 16'hFFFF, 1'b0, 1'b0, 8'h55, 4'h0, 1'b0, 8'h00, 8'h00, 16'h0001, 2'd0}, // 18 R7
        '{2'd0, 3'd0, 1'b1, 16'hFFFF, 1'b0, 1'b0, 8'h55, 4'h0, 1'b0, 8'h00, 8'h00, 16'h0000, 2'd0}, // 19 R7
        '{2'd1, 3'd0, 1'b0, 16'hFFFF, 1'b0, 1'b0, 8'h55, 4'h0, 1'b0, 8'h9A, 8'hBC, 16'h9ABC, 2'd2}, // 20 R7
        '{2'd0, 3'd4, 1'b0, 16'h6000, 1'b0, 1'b0, 8'h55, 4'h1, 1'b0, 8'h42, 8'h00, 16'h6042, 2'd1}, // 21 R2
        '{2'd1, 3'd2, 1'b0, 16'h7000, 1'b0, 1'b0, 8'h55, 4'h0, 1'b0, 8'h00, 8'h00, 16'h7002, 2'd0}  // 22 R5
    };

    function automatic string tag_of(input int k);
        if (k == 0 || k == 9)  return "R1";
        if (k == 1)            return "R3";
        if (k == 10 || k == 12) return "R4";
        if (k == 11 || k == 13 || k == 22) return "R5";
        if (k >= 14 && k <= 17) return "R6";
        if (k >= 18 && k <= 20) return "R7";
        return "R2";
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // run one operation: returns after the result pulse has been sampled
    task automatic run_op(input vec_t v, input string req);
        int  nbytes = 0;
        bit  seen = 1'b0;
        logic [15:0] got_pc = 16'h0;
        @(negedge clk);
        op_valid = 1'b1; op_kind = v.kind; op_cond = v.cond; op_invert = v.inv;
        op_pc = v.pc; flag_q = v.q; flag_df = v.df; acc = v.acc;
        ext_flag = v.ext; int_en = v.ie;
        @(negedge clk);
        op_valid = 1'b0;
        check(imm_need == v.exp_need, req, "imm_need after accept (R11)", 32'(imm_need), 32'(v.exp_need));
        if (v.exp_need == 2'd0)
            check(pc_valid == 1'b1, req, "pc_valid one cycle after accept (R8)", 32'(pc_valid), 32'd1);
        for (int step = 0; step < 10; step++) begin
            if (pc_valid) begin
                seen = 1'b1;
                got_pc = pc_out;
                break;
            end
            if (byte_req) begin
                check(byte_addr == v.pc + 16'(nbytes), req, "operand address", 32'(byte_addr), 32'(v.pc + 16'(nbytes)));
                byte_valid = 1'b1;
                byte_in = (nbytes == 0) ? v.b0 : v.b1;
                nbytes++;
                @(negedge clk);
                byte_valid = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        check(seen, req, "result pulse seen", 32'(seen), 32'd1);
        check(nbytes == int'(v.exp_need), req, "bytes fetched", 32'(nbytes), 32'(v.exp_need));
        check(got_pc == v.exp_pc, req, "new pc", 32'(got_pc), 32'(v.exp_pc));
        @(negedge clk);
        check(pc_valid == 1'b0, "R8", "pulse lasts one cycle", 32'(pc_valid), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(busy == 1'b0, "R10", "busy in reset", 32'(busy), 32'd0);
        check(byte_req == 1'b0, "R10", "byte_req in reset", 32'(byte_req), 32'd0);
        check(pc_valid == 1'b0, "R10", "pc_valid in reset", 32'(pc_valid), 32'd0);
        check(imm_need == 2'd0, "R10", "imm_need in reset", 32'(imm_need), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && pc_valid == 1'b0, "R10", "idle after release",
              32'({busy, pc_valid}), 32'd0);

        for (int k = 0; k < NV; k++) run_op(VECS[k], tag_of(k));

        // R9: reserved class is not accepted
        @(negedge clk);
        op_valid = 1'b1; op_kind = 2'b11; op_pc = 16'h0A00;
        @(negedge clk);
        op_valid = 1'b0;
        check(busy == 1'b0 && pc_valid == 1'b0, "R9", "reserved kind ignored",
              32'({busy, pc_valid}), 32'd0);

        // R9: an operation offered while busy is ignored
        begin
            int pulses = 0;
            logic [15:0] last_pc = 16'h0;
            int nb = 0;
            @(negedge clk);
            op_valid = 1'b1; op_kind = 2'b01; op_cond = 3'd0; op_invert = 1'b0;
            op_pc = 16'h8000;
            @(negedge clk);
            op_kind = 2'b00; op_invert = 1'b1; op_pc = 16'h9000; // would be a skip
            @(negedge clk);
            op_valid = 1'b0;
            for (int step = 0; step < 12; step++) begin
                if (pc_valid) begin
                    pulses++;
                    last_pc = pc_out;
                end
                if (byte_req && nb < 2) begin
                    byte_valid = 1'b1;
                    byte_in = (nb == 0) ? 8'h11 : 8'h22;
                    nb++;
                end
                @(negedge clk);
                byte_valid = 1'b0;
            end
            check(pulses == 1, "R9", "single result while busy", 32'(pulses), 32'd1);
            check(last_pc == 16'h1122, "R9", "first operation's target", 32'(last_pc), 32'h1122);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule